// File: doc/BRIEF.md
# Branch Record Ring Buffer

This block keeps a short history of the most recent taken control-flow transfers. A retired-branch event carries a source address, a target address, a kind code, the privilege of the target and three flags (mispredict, in-transaction, transaction-abort). The block writes each qualifying event into a circular buffer of source, target and info slots. A top-of-stack pointer always names the slot holding the newest record.

A small register port holds the control word and the select word, and lets software read or write the top-of-stack pointer and any slot by index. Software uses indexed writes to restore a saved history after a context switch. In the select word the low bits suppress branch kinds rather than enable them. A call-stack mode makes calls push and returns pop, so the buffer tracks the live call chain. A performance-monitor interrupt can freeze recording until software clears the freeze.

Top module: `branch_ring`

## Requirements
- R1: After reset every source, target and info slot reads zero, and the control, select and top-of-stack registers read zero.
- R2: When recording is enabled and not frozen, a valid event of kind 0..6 that no select bit suppresses is written to slot (tos+1) mod DEPTH, and tos moves to that slot. Kind 7 is never recorded. The entry i back from the newest sits at slot (tos-i)&(DEPTH-1).
- R3: A stored source word has bit 63 = mispredict, bit 62 = in-transaction, bit 61 = abort, and bits 60:0 hold the VA_W-bit source sign-extended. The target is stored sign-extended to 64 bits. The info slot holds bit 0 = mispredict, bit 1 = in-transaction, bit 2 = abort.
- R4: Select bit 0 suppresses events whose target is ring 0 (tgt_kernel=1). Bit 1 suppresses events whose target is not ring 0. Bit k+2 suppresses kind k. The kind codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch, 7 other.
- R5: With select bit 9 set (call-stack mode), an unsuppressed call (kind 1 or 2) records as in R2. An unsuppressed return (kind 3) decrements tos modulo DEPTH and writes nothing. Every other kind is ignored.
- R6: With control bit 1 (freeze enable) set and call-stack mode off, a pmi_i pulse sets control bit 2 (frozen). An event in the same cycle as the pulse is dropped, and no event is recorded while frozen. A control write with bit 2 = 0 clears frozen; writing bit 2 = 1 leaves it unchanged.
- R7: While call-stack mode is on, pmi_i never sets frozen.
- R8: With control bit 0 (enable) clear, no event changes any slot or tos.
- R9: Register addresses are {region[1:0], index}. Region 0 holds the control word (index 0), select (index 1) and tos (index 2). Regions 1, 2 and 3 hold the source, target and info slots. Every register, including tos and all slots, is writable while recording is disabled. An event arriving in a cycle with reg_we_i high is dropped.
- R10: A control write with bit 3 set zeroes every source, target and info slot. It leaves tos unchanged and bit 3 reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Retired taken-branch event valid |
| br_src_i | input | VA_W | Source address |
| br_dst_i | input | VA_W | Target address |
| br_kind_i | input | 3 | Branch kind code (R4) |
| br_tgt_kernel_i | input | 1 | Target privilege is ring 0 |
| br_mispred_i | input | 1 | Branch was mispredicted |
| br_in_tx_i | input | 1 | Branch inside a transaction |
| br_abort_i | input | 1 | Branch is a transaction abort |
| pmi_i | input | 1 | Performance-monitor interrupt pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | log2(DEPTH)+2 | Register address {region, index} |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational on reg_addr_i |

## Verification
The assertions assume that reg_we_i is a clean one-cycle strobe and that the event inputs are valid only when br_valid_i is high. They also assume that pmi_i arrives as isolated pulses, so a freeze and a software clear never fall in one cycle unless a test sets that up on purpose. The bench drives events and register writes only from the falling edge, holds each for exactly one cycle and returns everything to idle before reading. Reads therefore see settled state. The cases that deliberately coincide (an event with a freeze pulse, an event with a register write) are applied as explicit single-cycle overlaps.

// File: rtl/branch_ring_pkg.sv
package branch_ring_pkg;
  localparam int DATA_W  = 64;
  localparam int INFO_W  = 3;
  localparam int SEL_W   = 10;
  localparam int FILT_W  = 9;
  localparam int SEL_CSTK = 9;
  localparam int NKINDS  = 7;

  // control word bits
  localparam int CTL_EN     = 0;
  localparam int CTL_FRZ_EN = 1;
  localparam int CTL_FROZEN = 2;
  localparam int CTL_CLR    = 3;

  // region 0 sub-addresses
  localparam int SUB_CTRL = 0;
  localparam int SUB_SEL  = 1;
  localparam int SUB_TOS  = 2;

  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_SRC  = 2'd1;
  localparam logic [1:0] RG_DST  = 2'd2;
  localparam logic [1:0] RG_INFO = 2'd3;

  typedef enum logic [2:0] {
    K_COND  = 3'd0,
    K_RCALL = 3'd1,
    K_ICALL = 3'd2,
    K_RET   = 3'd3,
    K_IJMP  = 3'd4,
    K_RJMP  = 3'd5,
    K_FAR   = 3'd6,
    K_OTHER = 3'd7
  } br_kind_e;
endpackage

// File: rtl/branch_ring_filter.sv
module branch_ring_filter
  import branch_ring_pkg::*;
(
  input  logic             valid_i,
  input  logic [2:0]       kind_i,
  input  logic             tgt_kernel_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             allow_i,
  output logic             push_o,
  output logic             pop_o
);
  br_kind_e          kind;
  logic [FILT_W-1:0] hit;
  logic              suppress, is_call, is_ret, cstk, go;

  assign kind   = br_kind_e'(kind_i);
  assign hit[0] = tgt_kernel_i;
  assign hit[1] = ~tgt_kernel_i;

  for (genvar k = 0; k < NKINDS; k++) begin : g_kind
    assign hit[k+2] = (kind_i == 3'(k));
  end

  assign suppress = |(hit & sel_i[FILT_W-1:0]);
  assign cstk     = sel_i[SEL_CSTK];
  assign is_call  = (kind == K_RCALL) || (kind == K_ICALL);
  assign is_ret   = (kind == K_RET);
  assign go       = allow_i & valid_i & ~suppress;

  always_comb begin
    if (cstk) begin
      push_o = go & is_call;
      pop_o  = go & is_ret;
    end else begin
      push_o = go & (kind != K_OTHER);
      pop_o  = 1'b0;
    end
  end
endmodule

// File: rtl/branch_ring_ctrl.sv
module branch_ring_ctrl
  import branch_ring_pkg::*;
#(
  parameter int IDX_W = 4
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              sel_we_i,
  input  logic              tos_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pmi_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              en_o,
  output logic              frz_en_o,
  output logic              frozen_o,
  output logic              freeze_now_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [IDX_W-1:0]  tos_o
);
  logic             en_q, fe_q, frz_q;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] tos_q;

  // freeze is never armed in call-stack mode
  assign freeze_now_o = pmi_i & fe_q & ~sel_q[SEL_CSTK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      fe_q  <= 1'b0;
      frz_q <= 1'b0;
      sel_q <= '0;
      tos_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q <= wdata_i[CTL_EN];
        fe_q <= wdata_i[CTL_FRZ_EN];
      end
      if (freeze_now_o)   frz_q <= 1'b1;
      else if (ctrl_we_i) frz_q <= frz_q & wdata_i[CTL_FROZEN];
      if (sel_we_i) sel_q <= wdata_i[SEL_W-1:0];
      if (tos_we_i)     tos_q <= wdata_i[IDX_W-1:0];
      else if (push_i)  tos_q <= tos_q + 1'b1;
      else if (pop_i)   tos_q <= tos_q - 1'b1;
    end
  end

  assign en_o     = en_q;
  assign frz_en_o = fe_q;
  assign frozen_o = frz_q;
  assign sel_o    = sel_q;
  assign tos_o    = tos_q;
endmodule

// File: rtl/branch_ring_store.sv
module branch_ring_store
  import branch_ring_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  input  logic [DATA_W-1:0] push_src_i,
  input  logic [DATA_W-1:0] push_dst_i,
  input  logic [INFO_W-1:0] push_info_i,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_region_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_src_o,
  output logic [DATA_W-1:0] rd_dst_o,
  output logic [INFO_W-1:0] rd_info_o
);
  logic [DATA_W-1:0] src_a  [DEPTH];
  logic [DATA_W-1:0] dst_a  [DEPTH];
  logic [INFO_W-1:0] info_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] s_q, d_q;
    logic [INFO_W-1:0] i_q;
    logic              sw_hit, hw_hit;

    assign sw_hit = sw_we_i && (sw_idx_i == IDX_W'(g));
    assign hw_hit = push_i && (push_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= '0;
        d_q <= '0;
        i_q <= '0;
      end else if (clr_i) begin
        s_q <= '0;
        d_q <= '0;
        i_q <= '0;
      end else if (sw_hit) begin
        case (sw_region_i)
          RG_SRC:  s_q <= sw_wdata_i;
          RG_DST:  d_q <= sw_wdata_i;
          RG_INFO: i_q <= sw_wdata_i[INFO_W-1:0];
          default: ;
        endcase
      end else if (hw_hit) begin
        s_q <= push_src_i;
        d_q <= push_dst_i;
        i_q <= push_info_i;
      end
    end

    assign src_a[g]  = s_q;
    assign dst_a[g]  = d_q;
    assign info_a[g] = i_q;
  end

  assign rd_src_o  = src_a[rd_idx_i];
  assign rd_dst_o  = dst_a[rd_idx_i];
  assign rd_info_o = info_a[rd_idx_i];
endmodule

// File: rtl/branch_ring.sv
module branch_ring
  import branch_ring_pkg::*;
#(
  parameter int  DEPTH = 16,
  parameter int  VA_W  = 48,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RA_W  = IDX_W + 2
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [VA_W-1:0]   br_src_i,
  input  logic [VA_W-1:0]   br_dst_i,
  input  logic [2:0]        br_kind_i,
  input  logic              br_tgt_kernel_i,
  input  logic              br_mispred_i,
  input  logic              br_in_tx_i,
  input  logic              br_abort_i,
  input  logic              pmi_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int SEXT_W = DATA_W - INFO_W - VA_W;

  logic              en, frz_en, frozen, freeze_now, push, pop, clr, allow;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  tos, push_idx, reg_idx;
  logic [1:0]        region;
  logic              ctrl_we, sel_we, tos_we, ent_we;
  logic [DATA_W-1:0] push_src, push_dst, rd_src, rd_dst;
  logic [INFO_W-1:0] push_info, rd_info;

  assign region  = reg_addr_i[RA_W-1:IDX_W];
  assign reg_idx = reg_addr_i[IDX_W-1:0];
  assign ctrl_we = reg_we_i && (region == RG_CTRL) && (reg_idx == IDX_W'(SUB_CTRL));
  assign sel_we  = reg_we_i && (region == RG_CTRL) && (reg_idx == IDX_W'(SUB_SEL));
  assign tos_we  = reg_we_i && (region == RG_CTRL) && (reg_idx == IDX_W'(SUB_TOS));
  assign ent_we  = reg_we_i && (region != RG_CTRL);
  assign clr     = ctrl_we && reg_wdata_i[CTL_CLR];

  // any register write or a freeze in this cycle drops the event
  assign allow = en & ~frozen & ~freeze_now & ~reg_we_i;

  assign push_idx  = tos + 1'b1;
  assign push_src  = {br_mispred_i, br_in_tx_i, br_abort_i,
                      {SEXT_W{br_src_i[VA_W-1]}}, br_src_i};
  assign push_dst  = {{(DATA_W-VA_W){br_dst_i[VA_W-1]}}, br_dst_i};
  assign push_info = {br_abort_i, br_in_tx_i, br_mispred_i};

  branch_ring_filter u_filter (
    .valid_i      (br_valid_i),
    .kind_i       (br_kind_i),
    .tgt_kernel_i (br_tgt_kernel_i),
    .sel_i        (sel),
    .allow_i      (allow),
    .push_o       (push),
    .pop_o        (pop)
  );

  branch_ring_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .sel_we_i     (sel_we),
    .tos_we_i     (tos_we),
    .wdata_i      (reg_wdata_i),
    .pmi_i        (pmi_i),
    .push_i       (push),
    .pop_i        (pop),
    .en_o         (en),
    .frz_en_o     (frz_en),
    .frozen_o     (frozen),
    .freeze_now_o (freeze_now),
    .sel_o        (sel),
    .tos_o        (tos)
  );

  branch_ring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .push_i      (push),
    .push_idx_i  (push_idx),
    .push_src_i  (push_src),
    .push_dst_i  (push_dst),
    .push_info_i (push_info),
    .sw_we_i     (ent_we),
    .sw_region_i (region),
    .sw_idx_i    (reg_idx),
    .sw_wdata_i  (reg_wdata_i),
    .rd_idx_i    (reg_idx),
    .rd_src_o    (rd_src),
    .rd_dst_o    (rd_dst),
    .rd_info_o   (rd_info)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (region)
      RG_CTRL: begin
        if (reg_idx == IDX_W'(SUB_CTRL)) begin
          reg_rdata_o[CTL_EN]     = en;
          reg_rdata_o[CTL_FRZ_EN] = frz_en;
          reg_rdata_o[CTL_FROZEN] = frozen;
        end else if (reg_idx == IDX_W'(SUB_SEL)) begin
          reg_rdata_o[SEL_W-1:0] = sel;
        end else if (reg_idx == IDX_W'(SUB_TOS)) begin
          reg_rdata_o[IDX_W-1:0] = tos;
        end
      end
      RG_SRC:  reg_rdata_o = rd_src;
      RG_DST:  reg_rdata_o = rd_dst;
      default: reg_rdata_o[INFO_W-1:0] = rd_info;
    endcase
  end
endmodule

// File: rtl/branch_ring_chk.sv
module branch_ring_chk #(
  parameter int DEPTH = 16
)(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     reg_we_i,
  input logic [2:0]               br_kind_i,
  input logic                     push_i,
  input logic                     pop_i,
  input logic [$clog2(DEPTH)-1:0] tos_i,
  input logic                     frozen_i,
  input logic                     cstk_i,
  input logic                     en_i
);
  localparam int IW = $clog2(DEPTH);

  assert_push_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> tos_i == IW'($past(tos_i) + 1'b1));

  assert_other_kind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 3'd7) |-> !push_i);

  assert_pop_retreat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> tos_i == IW'($past(tos_i) - 1'b1));

  assert_frozen_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |-> !push_i && !pop_i);

  assert_no_freeze_cstk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstk_i && !frozen_i) |=> !frozen_i);

  assert_disabled_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !push_i && !pop_i);

  assert_sw_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !push_i && !pop_i);
endmodule

bind branch_ring branch_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .br_kind_i (br_kind_i),
  .push_i    (push),
  .pop_i     (pop),
  .tos_i     (tos),
  .frozen_i  (frozen),
  .cstk_i    (sel[9]),
  .en_i      (en)
);

// File: tb/branch_ring_bench.sv
module branch_ring_bench;
  localparam int DEPTH = 4;
  localparam int VA_W  = 16;
  localparam int IDX_W = 2;
  localparam int RA_W  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             br_valid, br_kern, br_mis, br_tx, br_ab, pmi, reg_we;
  logic [VA_W-1:0]  br_src, br_dst;
  logic [2:0]       br_kind;
  logic [RA_W-1:0]  reg_addr;
  logic [63:0]      reg_wdata, reg_rdata;

  branch_ring #(.DEPTH(DEPTH), .VA_W(VA_W)) u_branch_ring (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_src_i(br_src),
    .br_dst_i(br_dst), .br_kind_i(br_kind), .br_tgt_kernel_i(br_kern),
    .br_mispred_i(br_mis), .br_in_tx_i(br_tx), .br_abort_i(br_ab),
    .pmi_i(pmi), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // reference model
  logic [63:0]      m_src [DEPTH];
  logic [63:0]      m_dst [DEPTH];
  logic [2:0]       m_info[DEPTH];
  logic [IDX_W-1:0] m_tos;
  logic [9:0]       m_sel;
  logic             m_en, m_fe, m_frz;

  function automatic logic [RA_W-1:0] ad(input logic [1:0] r, input int i);
    return {r, 2'(i)};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [RA_W-1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [63:0] d;
    rd(ad(0, 0), d); chk(req, "ctrl", d, {61'b0, m_frz, m_fe, m_en});
    rd(ad(0, 1), d); chk(req, "select", d, {54'b0, m_sel});
    rd(ad(0, 2), d); chk(req, "tos", d, {62'b0, m_tos});
    for (int i = 0; i < DEPTH; i++) begin
      rd(ad(1, i), d); chk(req, $sformatf("src[%0d]", i), d, m_src[i]);
      rd(ad(2, i), d); chk(req, $sformatf("dst[%0d]", i), d, m_dst[i]);
      rd(ad(3, i), d); chk(req, $sformatf("info[%0d]", i), d, {61'b0, m_info[i]});
    end
  endtask

  task automatic model_wr(input logic [RA_W-1:0] a, input logic [63:0] d);
    int i;
    i = int'(a[1:0]);
    case (a[3:2])
      2'd0: begin
        if (i == 0) begin
          m_en  = d[0];
          m_fe  = d[1];
          m_frz = m_frz & d[2];
          if (d[3]) for (int k = 0; k < DEPTH; k++) begin   // R10 clear
            m_src[k] = '0; m_dst[k] = '0; m_info[k] = '0;
          end
        end else if (i == 1) m_sel = d[9:0];
        else if (i == 2) m_tos = d[1:0];
      end
      2'd1: m_src[i]  = d;
      2'd2: m_dst[i]  = d;
      default: m_info[i] = d[2:0];
    endcase
  endtask

  task automatic wr(input logic [RA_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  // one event; optionally a pmi pulse and a register write in the same cycle
  task automatic br(input logic [2:0] kind, input logic kern, input logic [VA_W-1:0] s,
                    input logic [VA_W-1:0] t, input logic [2:0] fl, input logic p,
                    input logic w, input logic [RA_W-1:0] wa, input logic [63:0] wd);
    logic frz_now, allow, supp;
    logic [60:0] s61;
    @(negedge clk);
    br_valid = 1'b1; br_kind = kind; br_kern = kern; br_src = s; br_dst = t;
    {br_mis, br_tx, br_ab} = fl; pmi = p;
    if (w) begin reg_we = 1'b1; reg_addr = wa; reg_wdata = wd; end
    @(posedge clk); #1;
    br_valid = 1'b0; pmi = 1'b0; reg_we = 1'b0;
    frz_now = p && m_fe && !m_sel[9];
    allow   = m_en && !m_frz && !frz_now && !w;
    supp    = (m_sel[0] && kern) || (m_sel[1] && !kern) || (kind < 3'd7 && m_sel[int'(kind) + 2]);
    if (w) model_wr(wa, wd);
    if (allow && !supp) begin
      if (m_sel[9] && kind == 3'd3) m_tos = m_tos - 1'b1;
      else if ((m_sel[9] && (kind == 3'd1 || kind == 3'd2)) || (!m_sel[9] && kind != 3'd7)) begin
        m_tos = m_tos + 1'b1;
        s61 = 61'($signed(s));
        m_src[m_tos]  = {fl, s61};
        m_dst[m_tos]  = 64'($signed(t));
        m_info[m_tos] = {fl[0], fl[1], fl[2]};
      end
    end
    if (frz_now) m_frz = 1'b1;
  endtask

  initial begin
    logic [63:0] d;
    logic [9:0]  s;
    string       tag;
    int          c;
    rst_n = 1'b0; br_valid = 0; br_kern = 0; br_mis = 0; br_tx = 0; br_ab = 0;
    pmi = 0; reg_we = 0; br_src = '0; br_dst = '0; br_kind = '0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_dst[i] = '0; m_info[i] = '0; end
    m_tos = '0; m_sel = '0; m_en = 0; m_fe = 0; m_frz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R3: literal format check
    wr(ad(0, 0), 64'h1);
    br(3'd0, 1'b0, 16'h8001, 16'hFFFE, 3'b010, 1'b0, 1'b0, '0, '0);
    rd(ad(1, 1), d); chk("R3", "src literal", d, 64'h5FFF_FFFF_FFFF_8001);
    rd(ad(2, 1), d); chk("R3", "dst literal", d, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(ad(3, 1), d); chk("R3", "info literal", d, 64'h2);
    check_all("R3");

    // sweep select patterns x kinds x privilege: R2, R4, R5
    c = 0;
    for (int b = -1; b <= 11; b++) begin
      if (b < 0)       begin s = 10'h000; tag = "R2"; end
      else if (b <= 8) begin s = 10'(1 << b); tag = "R4"; end
      else if (b == 9) begin s = 10'h200; tag = "R5"; end
      else if (b == 10) begin s = 10'h208; tag = "R5"; end
      else             begin s = 10'h0FC; tag = "R4"; end
      wr(ad(0, 1), {54'b0, s});
      for (int k = 0; k < 8; k++) begin
        for (int p = 0; p < 2; p++) begin
          c++;
          br(3'(k), p[0], 16'(c * 16'h1357) ^ (c[0] ? 16'h8000 : 16'h0),
             16'(c * 16'h2468 + 1), 3'(c), 1'b0, 1'b0, '0, '0);
          check_all(tag);
        end
      end
    end

    // R8: disabled
    wr(ad(0, 1), 64'h0);
    wr(ad(0, 0), 64'h0);
    br(3'd0, 1'b0, 16'h1234, 16'h4321, 3'b001, 1'b0, 1'b0, '0, '0);
    br(3'd6, 1'b1, 16'h9999, 16'h7777, 3'b100, 1'b0, 1'b0, '0, '0);
    check_all("R8");

    // R9: restore while disabled, then event dropped by a coincident write
    wr(ad(0, 2), 64'h2);
    wr(ad(1, 1), 64'hDEAD_BEEF_0000_1111);
    wr(ad(2, 1), 64'h0123_4567_89AB_CDEF);
    wr(ad(3, 1), 64'hFFFF_FFFF_FFFF_FFFD);
    check_all("R9");
    wr(ad(0, 0), 64'h1);
    br(3'd5, 1'b0, 16'h0042, 16'h0043, 3'b000, 1'b0, 1'b1, ad(1, 3), 64'hAAAA_5555_AAAA_5555);
    check_all("R9");

    // R10: clear keeps tos
    wr(ad(0, 0), 64'h9);
    check_all("R10");

    // R6: freeze
    wr(ad(0, 0), 64'h3);
    br(3'd0, 1'b0, 16'h0101, 16'h0202, 3'b000, 1'b1, 1'b0, '0, '0);
    check_all("R6");
    br(3'd4, 1'b1, 16'h0303, 16'h0404, 3'b000, 1'b0, 1'b0, '0, '0);
    check_all("R6");
    wr(ad(0, 0), 64'h7);
    check_all("R6");
    wr(ad(0, 0), 64'h3);
    br(3'd4, 1'b1, 16'h0505, 16'h0606, 3'b111, 1'b0, 1'b0, '0, '0);
    check_all("R6");

    // R7: no freeze in call-stack mode
    wr(ad(0, 1), 64'h200);
    br(3'd1, 1'b0, 16'h0707, 16'h0808, 3'b000, 1'b1, 1'b0, '0, '0);
    br(3'd2, 1'b1, 16'h0909, 16'h0A0A, 3'b000, 1'b1, 1'b0, '0, '0);
    check_all("R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule